// File: doc/BRIEF.md
# Packed multiply-accumulate unit

This block is a multiply-accumulate datapath that sits beside a processor pipeline and keeps a 40-bit running sum. Each issued operation carries a 32-bit instruction word and two 32-bit operands. The block decodes the instruction word and checks that its fixed fields are legal. It then adds one of three kinds of signed product to the sum:

- the full 32x32 product of the two operands;
- the sum of the two halfword-by-halfword products;
- a single 16x16 product of halves that the instruction picks.

An illegal encoding leaves the sum untouched and raises a one-cycle "undefined" pulse, so the host can take its illegal-instruction path.

The host can overwrite the whole accumulator through a load port. It reads the accumulator back as two 32-bit words: the low word, and the upper bits sign-extended to a full word. A load has priority over an operation issued in the same cycle. The arithmetic wraps modulo 2^ACC_W and never saturates. Operand and accumulator widths are parameters. A further parameter selects how the full-width product is built: either as one wide multiplier, or as four halfword partial products.

Top module: `pmac_unit`

## Requirements
- R1: A synchronous active-high `rst` clears the accumulator to zero and drops `undef`. The read port then shows `acc_lo`=0 and `acc_hi`=0.
- R2: Instruction bits [19:18] pick the operation: 00 full product, 10 dual halfword, 11 selected halfword. The code 01 is always undefined.
- R3: Any issued operation whose instruction bits [11:4] differ from 0x01 is undefined and leaves the accumulator unchanged.
- R4: Operation codes 00 and 10 are undefined unless instruction bits [17:16] are 00. Code 11 accepts any value of those bits.
- R5: Code 00 adds the product of `op_a` and `op_b` to the accumulator. Both operands are taken as signed 32-bit values, and the full product is added.
- R6: Code 10 adds two products at once. One is the product of the signed upper halves [31:16] of the operands. The other is the product of their signed lower halves [15:0].
- R7: Code 11 multiplies one half of each operand. Instruction bit 17 picks the half of `op_a` and bit 16 picks the half of `op_b`, with 1 meaning [31:16] and 0 meaning [15:0]. The product of the two signed halves is added.
- R8: Every 16x16 product is a signed 32-bit value. It is sign-extended before it is added. The sum wraps modulo 2^40 with no saturation.
- R9: When `ld_en` is high, the accumulator takes all 40 bits of `ld_data` at the next edge. This holds even when a legal operation is issued in the same cycle.
- R10: `acc_lo` shows accumulator bits [31:0]. `acc_hi` shows bits [39:32] sign-extended to 32 bits.
- R11: An issued operation changes the accumulator at the next clock edge. `undef` is high for exactly the one cycle after an undefined issue. With `op_valid` low, the accumulator holds and `undef` stays low whatever the instruction bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Issues the operation on `op_instr`, `op_a` and `op_b` |
| op_instr | input | 32 | Instruction word |
| op_a | input | OP_W (32) | First source operand |
| op_b | input | OP_W (32) | Second source operand |
| ld_en | input | 1 | Loads `ld_data` into the accumulator |
| ld_data | input | ACC_W (40) | Load value |
| acc_lo | output | OP_W (32) | Accumulator low word |
| acc_hi | output | OP_W (32) | Accumulator upper bits, sign-extended |
| undef | output | 1 | One-cycle pulse after an undefined issue |

## Verification
The accumulator is the only state in this block, and it is visible at the read port one edge after each operation. A wrong partial product or a wrong sign extension therefore shows up on `acc_lo` or `acc_hi` within one cycle. Once the error is in the sum, every later readback carries it. A decode fault shows up at the same edge: either `undef` pulses when it should not, or the sum moves on an illegal encoding. The bench sweeps every combination of operation code and halfword-select bits over a set of corner operands, then runs random operations. It compares each readback against an arithmetic model kept in the bench.

// File: rtl/pmac_pkg.sv
package pmac_pkg;

   localparam int INSTR_W  = 32;
   localparam int MODE_LSB = 18;
   localparam int HSEL_LSB = 16;
   localparam int FIX_LSB  = 4;
   localparam int FIX_W    = 8;
   localparam logic [FIX_W-1:0] FIX_VAL = 8'h01;

   typedef enum logic [1:0] {
      MODE_FULL = 2'b00,
      MODE_BAD  = 2'b01,
      MODE_DUAL = 2'b10,
      MODE_SEL  = 2'b11
   } mac_mode_e;

   typedef struct packed {
      logic      legal;
      mac_mode_e mode;
      logic      sel_a_hi;
      logic      sel_b_hi;
   } mac_dec_t;

endpackage

// File: rtl/pmac_decode.sv
module pmac_decode
   import pmac_pkg::*;
(
   input  logic [INSTR_W-1:0] instr,
   output mac_dec_t           dec
);

   logic [1:0]       mode_bits;
   logic [1:0]       hsel_bits;
   logic [FIX_W-1:0] fix_bits;
   logic             fix_ok;
   logic             hsel_zero;
   logic             unused_instr;

   assign mode_bits = instr[MODE_LSB +: 2];
   assign hsel_bits = instr[HSEL_LSB +: 2];
   assign fix_bits  = instr[FIX_LSB +: FIX_W];
   assign unused_instr = ^{instr[INSTR_W-1:MODE_LSB+2], instr[HSEL_LSB-1:FIX_LSB+FIX_W],
                           instr[FIX_LSB-1:0]};

   assign fix_ok    = (fix_bits == FIX_VAL);
   assign hsel_zero = (hsel_bits == 2'b00);

   always_comb begin
      dec.mode     = mac_mode_e'(mode_bits);
      dec.sel_a_hi = hsel_bits[1];
      dec.sel_b_hi = hsel_bits[0];
      unique case (mac_mode_e'(mode_bits))
         MODE_FULL: dec.legal = fix_ok & hsel_zero;
         MODE_DUAL: dec.legal = fix_ok & hsel_zero;
         MODE_SEL:  dec.legal = fix_ok;
         default:   dec.legal = 1'b0;
      endcase
   end

endmodule

// File: rtl/pmac_full_mult.sv
module pmac_full_mult #(
   parameter int OP_W     = 32,
   parameter int ACC_W    = 40,
   parameter int MUL_ARCH = 0
) (
   input  logic [OP_W-1:0]  a,
   input  logic [OP_W-1:0]  b,
   output logic [ACC_W-1:0] prod
);

   localparam int H  = OP_W / 2;
   localparam int PW = 2 * OP_W;

   if (MUL_ARCH == 0) begin : g_direct
      logic signed [PW-1:0] wide;
      assign wide = $signed(a) * $signed(b);
      assign prod = wide[ACC_W-1:0];
   end else begin : g_split
      logic signed [H-1:0]   ah, bh;
      logic        [H-1:0]   al, bl;
      logic signed [2*H-1:0] p_hh;
      logic signed [2*H:0]   p_hl, p_lh;
      logic        [2*H-1:0] p_ll;
      logic        [ACC_W-1:0] w_hh, w_hl, w_lh, w_ll;

      assign ah = $signed(a[OP_W-1:H]);
      assign bh = $signed(b[OP_W-1:H]);
      assign al = a[H-1:0];
      assign bl = b[H-1:0];

      assign p_hh = ah * bh;
      assign p_hl = ah * $signed({1'b0, bl});
      assign p_lh = $signed({1'b0, al}) * bh;
      assign p_ll = al * bl;

      assign w_hh = {{(ACC_W-2*H){p_hh[2*H-1]}}, p_hh};
      assign w_hl = {{(ACC_W-2*H-1){p_hl[2*H]}}, p_hl};
      assign w_lh = {{(ACC_W-2*H-1){p_lh[2*H]}}, p_lh};
      assign w_ll = {{(ACC_W-2*H){1'b0}}, p_ll};

      assign prod = (w_hh << (2*H)) + ((w_hl + w_lh) << H) + w_ll;
   end

endmodule

// File: rtl/pmac_half_lanes.sv
module pmac_half_lanes
   import pmac_pkg::*;
#(
   parameter int HALF_W = 16,
   parameter int ACC_W  = 40
) (
   input  logic [2*HALF_W-1:0] a,
   input  logic [2*HALF_W-1:0] b,
   input  mac_mode_e           mode,
   input  logic                sel_a_hi,
   input  logic                sel_b_hi,
   output logic [ACC_W-1:0]    sum
);

   localparam int PW  = 2 * HALF_W;
   localparam int EXT = ACC_W - PW;
   localparam int LANES = 2;

   logic [ACC_W-1:0] lane_term [LANES];

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [HALF_W-1:0]    xa, xb;
      logic                 lane_on;
      logic signed [PW-1:0] prod;

      always_comb begin
         if (mode == MODE_SEL) begin
            lane_on = (l == 0);
            xa = sel_a_hi ? a[PW-1:HALF_W] : a[HALF_W-1:0];
            xb = sel_b_hi ? b[PW-1:HALF_W] : b[HALF_W-1:0];
         end else begin
            lane_on = 1'b1;
            xa = a[l*HALF_W +: HALF_W];
            xb = b[l*HALF_W +: HALF_W];
         end
      end

      assign prod = $signed(xa) * $signed(xb);
      assign lane_term[l] = lane_on ? {{EXT{prod[PW-1]}}, prod} : '0;
   end

   assign sum = lane_term[0] + lane_term[1];

endmodule

// File: rtl/pmac_acc.sv
module pmac_acc #(
   parameter int ACC_W = 40
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ld_en,
   input  logic [ACC_W-1:0] ld_data,
   input  logic             add_en,
   input  logic [ACC_W-1:0] add_val,
   output logic [ACC_W-1:0] acc
);

   always_ff @(posedge clk) begin
      if (rst)         acc <= '0;
      else if (ld_en)  acc <= ld_data;
      else if (add_en) acc <= acc + add_val;
   end

endmodule

// File: rtl/pmac_unit.sv
module pmac_unit
   import pmac_pkg::*;
#(
   parameter int OP_W     = 32,
   parameter int ACC_W    = 40,
   parameter int MUL_ARCH = 0
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               op_valid,
   input  logic [INSTR_W-1:0] op_instr,
   input  logic [OP_W-1:0]    op_a,
   input  logic [OP_W-1:0]    op_b,
   input  logic               ld_en,
   input  logic [ACC_W-1:0]   ld_data,
   output logic [OP_W-1:0]    acc_lo,
   output logic [OP_W-1:0]    acc_hi,
   output logic               undef
);

   localparam int HALF_W = OP_W / 2;
   localparam int HI_W   = ACC_W - OP_W;
   localparam int HI_EXT = OP_W - HI_W;

   if (OP_W % 2 != 0 || OP_W < 4) begin : g_bad_op_w
      $error("pmac_unit: OP_W must be even and at least 4");
   end
   if (ACC_W < OP_W + 2 || ACC_W >= 2 * OP_W) begin : g_bad_acc_w
      $error("pmac_unit: ACC_W must lie in [OP_W+2, 2*OP_W-1]");
   end
   if (MUL_ARCH != 0 && MUL_ARCH != 1) begin : g_bad_arch
      $error("pmac_unit: MUL_ARCH must be 0 or 1");
   end

   mac_dec_t         dec;
   logic [ACC_W-1:0] full_term;
   logic [ACC_W-1:0] half_term;
   logic [ACC_W-1:0] add_val;
   logic             add_en;
   logic [ACC_W-1:0] acc;
   logic             undef_q;

   pmac_decode u_dec (
      .instr (op_instr),
      .dec   (dec)
   );

   pmac_full_mult #(.OP_W(OP_W), .ACC_W(ACC_W), .MUL_ARCH(MUL_ARCH)) u_full (
      .a    (op_a),
      .b    (op_b),
      .prod (full_term)
   );

   pmac_half_lanes #(.HALF_W(HALF_W), .ACC_W(ACC_W)) u_half (
      .a        (op_a),
      .b        (op_b),
      .mode     (dec.mode),
      .sel_a_hi (dec.sel_a_hi),
      .sel_b_hi (dec.sel_b_hi),
      .sum      (half_term)
   );

   assign add_val = (dec.mode == MODE_FULL) ? full_term : half_term;
   assign add_en  = op_valid & dec.legal;

   pmac_acc #(.ACC_W(ACC_W)) u_acc (
      .clk     (clk),
      .rst     (rst),
      .ld_en   (ld_en),
      .ld_data (ld_data),
      .add_en  (add_en),
      .add_val (add_val),
      .acc     (acc)
   );

   always_ff @(posedge clk) begin
      if (rst) undef_q <= 1'b0;
      else     undef_q <= op_valid & ~dec.legal;
   end

   assign undef  = undef_q;
   assign acc_lo = acc[OP_W-1:0];
   assign acc_hi = {{HI_EXT{acc[ACC_W-1]}}, acc[ACC_W-1:OP_W]};

endmodule

// File: rtl/pmac_checker.sv
module pmac_checker #(
   parameter int OP_W  = 32,
   parameter int ACC_W = 40
) (
   input logic             clk,
   input logic             rst,
   input logic             op_valid,
   input logic [1:0]       mode_f,
   input logic [1:0]       hsel_f,
   input logic [7:0]       fix_f,
   input logic             ld_en,
   input logic [ACC_W-1:0] ld_data,
   input logic [OP_W-1:0]  acc_lo,
   input logic [OP_W-1:0]  acc_hi,
   input logic             undef
);

   logic [ACC_W-1:0] acc_w;
   assign acc_w = {acc_hi[ACC_W-OP_W-1:0], acc_lo};

   // R2: code 01 never accepted
   a_r2_mode01_undef: assert property (@(posedge clk) disable iff (rst)
      (op_valid && mode_f == 2'b01) |=> undef);

   // R3: bad fixed field flags and leaves the sum alone
   a_r3_fix_undef_hold: assert property (@(posedge clk) disable iff (rst)
      (op_valid && fix_f != 8'h01 && !ld_en) |=> (undef && $stable(acc_w)));

   // R4: select bits must be zero for codes 00 and 10
   a_r4_hsel_undef: assert property (@(posedge clk) disable iff (rst)
      (op_valid && fix_f == 8'h01 && !mode_f[0] && hsel_f != 2'b00) |=> undef);

   // R4: code 11 accepts any select bits
   a_r4_sel_mode_legal: assert property (@(posedge clk) disable iff (rst)
      (op_valid && fix_f == 8'h01 && mode_f == 2'b11) |=> !undef);

   // R9: load wins over any issue
   a_r9_load_wins: assert property (@(posedge clk) disable iff (rst)
      ld_en |=> (acc_w == $past(ld_data)));

   // R10: upper read word is the sign-extended top bits
   a_r10_hi_sext: assert property (@(posedge clk) disable iff (rst)
      ld_en |=> ($signed(acc_hi) == $signed($past(ld_data[ACC_W-1:OP_W]))));

   // R11: idle cycles hold the sum and never flag
   a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
      (!op_valid && !ld_en) |=> ($stable(acc_w) && !undef));

endmodule

bind pmac_unit pmac_checker #(.OP_W(OP_W), .ACC_W(ACC_W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .op_valid (op_valid),
   .mode_f   (op_instr[19:18]),
   .hsel_f   (op_instr[17:16]),
   .fix_f    (op_instr[11:4]),
   .ld_en    (ld_en),
   .ld_data  (ld_data),
   .acc_lo   (acc_lo),
   .acc_hi   (acc_hi),
   .undef    (undef)
);

// File: tb/pmac_unit_test.sv
module pmac_unit_test;

   localparam int CLK_P = 10;
   localparam int OP_W  = 32;
   localparam int ACC_W = 40;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              op_valid = 1'b0;
   logic [31:0]       op_instr = '0;
   logic [OP_W-1:0]   op_a = '0;
   logic [OP_W-1:0]   op_b = '0;
   logic              ld_en = 1'b0;
   logic [ACC_W-1:0]  ld_data = '0;
   logic [OP_W-1:0]   acc_lo;
   logic [OP_W-1:0]   acc_hi;
   logic              undef;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;
   logic [ACC_W-1:0] exp_acc = '0;

   always #(CLK_P/2) clk = ~clk;

   pmac_unit #(.OP_W(OP_W), .ACC_W(ACC_W)) uut (
      .clk(clk), .rst(rst), .op_valid(op_valid), .op_instr(op_instr),
      .op_a(op_a), .op_b(op_b), .ld_en(ld_en), .ld_data(ld_data),
      .acc_lo(acc_lo), .acc_hi(acc_hi), .undef(undef)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] sext_hi(input logic [ACC_W-1:0] v);
      logic [63:0] r;
      r = {{(64-ACC_W){v[ACC_W-1]}}, v};
      return {32'h0, r[63:32]};
   endfunction

   task automatic chk_acc(input string req);
      chk(acc_lo == exp_acc[31:0], req, {32'h0, acc_lo}, {32'h0, exp_acc[31:0]});
      chk({32'h0, acc_hi} == sext_hi(exp_acc), {req, " (R10 hi word)"},
          {32'h0, acc_hi}, sext_hi(exp_acc));
   endtask

   function automatic bit model_legal(input logic [31:0] ins);
      if (ins[11:4] != 8'h01) return 1'b0;
      case (ins[19:18])
         2'b00, 2'b10: return ins[17:16] == 2'b00;
         2'b11:        return 1'b1;
         default:      return 1'b0;
      endcase
   endfunction

   function automatic logic [ACC_W-1:0] model_term(input logic [31:0] ins,
                                                  input logic [31:0] a,
                                                  input logic [31:0] b);
      longint p;
      logic [63:0] t;
      logic [15:0] x, y;
      case (ins[19:18])
         2'b00: p = longint'($signed(a)) * longint'($signed(b));
         2'b10: p = longint'($signed(a[31:16])) * longint'($signed(b[31:16]))
                  + longint'($signed(a[15:0])) * longint'($signed(b[15:0]));
         default: begin
            x = ins[17] ? a[31:16] : a[15:0];
            y = ins[16] ? b[31:16] : b[15:0];
            p = longint'($signed(x)) * longint'($signed(y));
         end
      endcase
      t = p;
      return t[ACC_W-1:0];
   endfunction

   // Called at a negedge; returns at the following negedge.
   task automatic issue(input logic [31:0] ins, input logic [31:0] a,
                        input logic [31:0] b, input string req);
      bit lg;
      lg = model_legal(ins);
      op_valid = 1'b1; op_instr = ins; op_a = a; op_b = b;
      @(posedge clk);
      @(negedge clk);
      op_valid = 1'b0;
      if (lg) exp_acc = exp_acc + model_term(ins, a, b);
      chk(undef == !lg, {req, " (R11 undef pulse)"}, {63'h0, undef}, {63'h0, !lg});
      chk_acc(req);
   endtask

   task automatic load(input logic [ACC_W-1:0] v);
      ld_en = 1'b1; ld_data = v;
      @(posedge clk);
      @(negedge clk);
      ld_en = 1'b0;
      exp_acc = v;
   endtask

   function automatic logic [31:0] mk(input logic [1:0] mode, input logic [1:0] hs,
                                     input logic [7:0] fx);
      logic [31:0] r;
      r = 32'hE000_0000 | {12'h0, mode, hs, 4'h0, fx, 4'h0};
      return r;
   endfunction

   logic [31:0] corner [8] = '{32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF,
                               32'h7FFF_FFFF, 32'h8000_0000, 32'h0001_8000,
                               32'h8000_7FFF, 32'h1234_ABCD};

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1: reset state
      chk(acc_lo == 0 && acc_hi == 0, "R1 reset acc", {acc_hi, acc_lo}, 64'h0);
      chk(undef == 1'b0, "R1 reset undef", {63'h0, undef}, 64'h0);

      // R2 R4 R5 R6 R7 R8: every code and select value over corner operands
      for (int m = 0; m < 4; m++)
         for (int h = 0; h < 4; h++)
            for (int i = 0; i < 8; i++)
               for (int j = 0; j < 8; j += 3)
                  issue(mk(2'(m), 2'(h), 8'h01), corner[i], corner[j],
                        "R2 R4 R5 R6 R7 R8 sweep");

      // R3: fixed field sweep; only 0x01 accepted
      for (int f = 0; f < 256; f += 17)
         for (int m = 0; m < 4; m++)
            issue(mk(2'(m), 2'b00, 8'(f)), 32'h0003_0005, 32'hFFFD_0007, "R3 fixed field");
      issue(mk(2'b11, 2'b10, 8'h81), 32'h7FFF_0002, 32'h0004_8000, "R3 high bit set");

      // R8: wrap with no saturation
      load(40'h7F_FFFF_FFFF);
      issue(mk(2'b00, 2'b00, 8'h01), 32'h1, 32'h1, "R8 wrap to negative");
      chk(acc_hi == 32'hFFFF_FF80, "R8 wrap hi", {32'h0, acc_hi}, 64'hFFFF_FF80);
      load(40'hFF_FFFF_FFFF);
      issue(mk(2'b10, 2'b00, 8'h01), 32'h0000_0001, 32'h0000_0001, "R8 wrap to zero");
      chk(acc_lo == 0 && acc_hi == 0, "R8 zero after wrap", {acc_hi, acc_lo}, 64'h0);

      // R9: load priority over a legal issue in the same cycle
      load(40'h00_0000_0010);
      ld_en = 1'b1; ld_data = 40'hA5_1234_5678;
      op_valid = 1'b1; op_instr = mk(2'b00, 2'b00, 8'h01); op_a = 32'h100; op_b = 32'h100;
      @(posedge clk); @(negedge clk);
      ld_en = 1'b0; op_valid = 1'b0;
      exp_acc = 40'hA5_1234_5678;
      chk_acc("R9 load beats issue");
      chk(acc_hi == 32'hFFFF_FFA5, "R9 R10 load hi", {32'h0, acc_hi}, 64'hFFFF_FFA5);

      // R11: idle cycles hold regardless of instruction bits
      op_instr = mk(2'b01, 2'b11, 8'h00); op_a = 32'hFFFF_FFFF; op_b = 32'h8000_0000;
      repeat (3) @(negedge clk);
      chk(undef == 1'b0, "R11 idle undef", {63'h0, undef}, 64'h0);
      chk_acc("R11 idle hold");

      // R5 R6 R7: random operations
      load('0);
      for (int k = 0; k < 1500; k++) begin
         logic [31:0] ins;
         ins = $urandom;
         if ($urandom_range(3) != 0) ins[11:4] = 8'h01;
         issue(ins, $urandom, $urandom, "R5 R6 R7 random");
      end

      // R1: mid-run reset
      load(40'h12_3456_789A);
      rst = 1'b1;
      op_valid = 1'b1; op_instr = mk(2'b01, 2'b00, 8'h01);
      @(posedge clk); @(negedge clk);
      rst = 1'b0; op_valid = 1'b0;
      chk(acc_lo == 0 && acc_hi == 0, "R1 mid-run reset", {acc_hi, acc_lo}, 64'h0);
      chk(undef == 1'b0, "R1 reset masks undef", {63'h0, undef}, 64'h0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule